// File: doc/BRIEF.md
# Self-Clocked Converter Serial Readout

This block is the digital serial port of a sampling converter when the converter supplies its own serial clock. The host pulls chip select low and the block drives its data output with a live conversion status bit. Once a result is ready, the block waits a fixed number of system clocks and then generates its own serial clock. On that clock it shifts out a 24-bit frame, most significant bit first: a zero status bit followed by the 23-bit result. On the rising edges it also captures a 24-bit configuration word from the data input.

Conversion is modelled outside the block as a busy interval. The block raises a one-cycle start strobe on the last falling clock edge of a frame and then reports busy. The result is latched when the conversion-done pulse arrives. If the host releases chip select before the first clock edge, nothing is shifted and no conversion starts, so the block goes back to sleep still holding its result. A strap input selects which of two delay counts applies: one for the internal oscillator and one for an external oscillator.

Top module: `selfclk_readout`

## Requirements
- R1: `sdo_oe` is low out of reset, and it is low from the second system clock after `cs_n` goes high until `cs_n` goes low again.
- R2: Two system clocks after `cs_n` falls, `sdo_oe` is high, `sck` is low and `sdo` shows the status: 1 while a conversion runs, 0 when a result is ready.
- R3: With no conversion running, the first rising edge of `sck` is seen exactly DLY+2 system clocks after `cs_n` falls. DLY is `DLY_INT` when `clk_src_ext`=0 and `DLY_EXT` when `clk_src_ext`=1. While a conversion runs, the delay is held at its start value.
- R4: If `cs_n` rises before the first rising edge of `sck`, no `sck` edge and no `conv_start` occur, and the stored result is kept for the next frame.
- R5: `sck` has a 50% duty cycle with a high time of `HALF` system clocks. `sdo` changes only together with a falling `sck` edge, and `sdi` is sampled on each rising edge.
- R6: The frame is 24 bits. Bit 1 is the status bit, which is 0, and it is followed by `conv_data[22:0]`, MSB first.
- R7: On the 24th falling `sck` edge, `sdo` goes to 1 and `conv_start` pulses for one system clock. From then on `sdo` reports busy until `conv_done`.
- R8: A `conv_done` pulse during a conversion loads `conv_data` into the result register and clears the busy status, which appears live on `sdo`.
- R9: After the 24th bit, `sck` stays low until `cs_n` has gone high and then low again.
- R10: The 24 `sdi` bits are presented on `cfg_word`, with the first bit captured at bit 23. `cfg_valid` pulses in the same cycle as `conv_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sdi | input | 1 | Serial configuration data in |
| clk_src_ext | input | 1 | Strap: 1 selects the external-oscillator delay |
| conv_done | input | 1 | One-cycle pulse at the end of a conversion |
| conv_data | input | FRAME-1 | Conversion result, valid with `conv_done` |
| sck | output | 1 | Generated serial clock |
| sdo | output | 1 | Serial data / status out |
| sdo_oe | output | 1 | Output enable for `sdo` (0 = high impedance) |
| conv_start | output | 1 | One-cycle strobe that starts a conversion |
| cfg_word | output | FRAME | Captured configuration word |
| cfg_valid | output | 1 | One-cycle strobe when `cfg_word` updates |

## Verification
The hardest case to reach is a chip select that falls while a conversion is still running. There the status must read 1, then drop live when the result arrives, and the delay must be held until that moment. The stimulus reaches it by opening the next frame a few cycles after the previous frame's 24th edge, well inside the modelled busy time. A second hard case is the early abort. It is reached by releasing chip select halfway through the delay, and the frame that follows must return the same result unchanged.

// File: rtl/selfclk_readout.sv
module selfclk_readout #(
  parameter int FRAME   = 24,
  parameter int DLY_INT = 600,
  parameter int DLY_EXT = 180,
  parameter int HALF    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sdi,
  input  logic             clk_src_ext,
  input  logic             conv_done,
  input  logic [FRAME-2:0] conv_data,
  output logic             sck,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             conv_start,
  output logic [FRAME-1:0] cfg_word,
  output logic             cfg_valid
);
  localparam int DMAX = (DLY_INT > DLY_EXT) ? DLY_INT : DLY_EXT;
  localparam int CW   = $clog2(DMAX + 1);
  localparam int HW   = $clog2(HALF + 1);
  localparam int BW   = $clog2(FRAME + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SHIFT, S_DONE} st_t;

  st_t             state;
  logic            csn_q, busy;
  logic [CW-1:0]   dcnt;
  logic [HW-1:0]   hcnt;
  logic [BW-1:0]   nfall;
  logic [FRAME-2:0] res;
  logic [FRAME-1:0] sreg, cfg_sh;
  logic [CW-1:0]   dly_ld;

  assign dly_ld = clk_src_ext ? CW'(DLY_EXT - 1) : CW'(DLY_INT - 1);
  assign sdo_oe = (state != S_IDLE);
  assign sdo    = (state == S_SHIFT) ? sreg[FRAME-1] : busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      csn_q      <= 1'b1;
      busy       <= 1'b0;
      dcnt       <= '0;
      hcnt       <= '0;
      nfall      <= '0;
      res        <= '0;
      sreg       <= '0;
      cfg_sh     <= '0;
      cfg_word   <= '0;
      cfg_valid  <= 1'b0;
      conv_start <= 1'b0;
      sck        <= 1'b0;
    end else begin
      csn_q      <= cs_n;
      conv_start <= 1'b0;
      cfg_valid  <= 1'b0;
      if (conv_done && busy) begin
        res  <= conv_data;
        busy <= 1'b0;
      end
      case (state)
        S_IDLE: begin
          sck  <= 1'b0;
          dcnt <= dly_ld;
          if (!csn_q) state <= S_WAIT;
        end
        S_WAIT: begin
          if (csn_q) state <= S_IDLE;
          else if (busy) dcnt <= dly_ld;
          else if (dcnt == '0) begin
            state  <= S_SHIFT;
            sck    <= 1'b1;
            sreg   <= {1'b0, res};
            cfg_sh <= {cfg_sh[FRAME-2:0], sdi};
            hcnt   <= HW'(HALF - 1);
            nfall  <= '0;
          end else dcnt <= dcnt - 1'b1;
        end
        S_SHIFT: begin
          if (csn_q) begin
            state <= S_IDLE;
            sck   <= 1'b0;
          end else if (hcnt != '0) hcnt <= hcnt - 1'b1;
          else begin
            hcnt <= HW'(HALF - 1);
            sck  <= ~sck;
            if (sck) begin
              if (nfall == BW'(FRAME - 1)) begin
                state      <= S_DONE;
                busy       <= 1'b1;
                conv_start <= 1'b1;
                cfg_word   <= cfg_sh;
                cfg_valid  <= 1'b1;
              end else begin
                sreg  <= {sreg[FRAME-2:0], 1'b0};
                nfall <= nfall + 1'b1;
              end
            end else cfg_sh <= {cfg_sh[FRAME-2:0], sdi};
          end
        end
        default: begin
          sck <= 1'b0;
          if (csn_q) state <= S_IDLE;
        end
      endcase
    end
  end

  // R1
  hiz_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_q |=> !sdo_oe);

  // R7
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> sdo);

  // R10
  cfg_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> conv_start);

  // R9
  no_sck_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> !busy);

  // R5
  sdo_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHIFT && $past(state) == S_SHIFT && !$fell(sck)) |-> $stable(sdo));
endmodule

// File: tb/sim_selfclk_readout.sv
module sim_selfclk_readout;
  localparam int FRAME = 24;
  localparam int DI    = 60;
  localparam int DE    = 18;
  localparam int H     = 2;
  localparam int BUSY  = 100;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sdi = 1'b0, clk_src_ext = 1'b0;
  logic conv_done;
  logic [FRAME-2:0] conv_data;
  logic sck, sdo, sdo_oe, conv_start, cfg_valid;
  logic [FRAME-1:0] cfg_word;

  int checks = 0, fails = 0, rises = 0, nconv = 0;
  bit ended = 0;
  logic sck_prev = 1'b0;
  logic q[$];

  always #10 clk = ~clk;

  selfclk_readout #(.FRAME(FRAME), .DLY_INT(DI), .DLY_EXT(DE), .HALF(H)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi), .clk_src_ext(clk_src_ext),
    .conv_done(conv_done), .conv_data(conv_data), .sck(sck), .sdo(sdo),
    .sdo_oe(sdo_oe), .conv_start(conv_start), .cfg_word(cfg_word), .cfg_valid(cfg_valid));

  function automatic logic [FRAME-2:0] res_of(input int k);
    return (FRAME-1)'(23'h2A5C39 ^ (k * 23'h13579));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
  endtask

  // conversion model: busy interval, then done pulse with next result
  initial begin
    conv_done = 1'b0;
    conv_data = '0;
    forever begin
      @(negedge clk);
      if (conv_start) begin
        repeat (BUSY) @(negedge clk);
        conv_data = res_of(nconv);
        conv_done = 1'b1;
        nconv++;
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  // monitor: compare sdo against the scoreboard on each rising sck (R6)
  always @(negedge clk) begin
    if (sck && !sck_prev) begin
      rises++;
      if (q.size() == 0) chk(1'b0, "R6 unexpected sck bit", 32'(sdo), 32'hx);
      else begin
        logic e;
        e = q.pop_front();
        chk(sdo == e, "R6 frame bit", 32'(sdo), 32'(e));
      end
    end
    sck_prev <= sck;
  end

  task automatic do_read(input logic exp_stat, input logic [FRAME-2:0] exp_res,
                         input logic [FRAME-1:0] cfg, input logic ext, input bit chk_dly);
    logic [FRAME-1:0] bits;
    int n, hc, r0;
    bits = {1'b0, exp_res};
    for (int i = FRAME - 1; i >= 0; i--) q.push_back(bits[i]);
    clk_src_ext = ext;
    sdi = cfg[FRAME-1];
    @(negedge clk);
    cs_n = 1'b0;
    n = 0;
    while (!sck) begin
      @(negedge clk);
      n++;
      if (n == 2) begin
        chk(sdo_oe && !sck, "R2 enable and sck low", {30'd0, sdo_oe, sck}, 32'h2);
        chk(sdo == exp_stat, "R2 status bit", 32'(sdo), 32'(exp_stat));
      end
    end
    if (chk_dly) chk(n == (ext ? DE : DI) + 2, "R3 delay to first sck", n, (ext ? DE : DI) + 2);
    for (int i = 0; i < FRAME; i++) begin
      hc = 0;
      while (sck) begin
        @(negedge clk);
        hc++;
      end
      if (i == 0) chk(hc == H, "R5 sck high time", hc, H);
      if (i < FRAME - 1) begin
        sdi = cfg[FRAME-2-i];
        while (!sck) @(negedge clk);
      end
    end
    chk(sdo == 1'b1, "R7 sdo high after last edge", 32'(sdo), 1);
    chk(conv_start == 1'b1, "R7 conv_start pulse", 32'(conv_start), 1);
    chk(cfg_valid && cfg_word == cfg, "R10 cfg word", cfg_word, cfg);
    @(negedge clk);
    chk(conv_start == 1'b0, "R7 conv_start one cycle", 32'(conv_start), 0);
    r0 = rises;
    repeat (6 * H) @(negedge clk);
    chk(rises == r0 && q.size() == 0, "R9 no sck after frame", rises - r0, 0);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!sdo_oe, "R1 high impedance after deselect", 32'(sdo_oe), 0);
  endtask

  task automatic do_abort;
    bit seen;
    clk_src_ext = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(sdo_oe && sdo == 1'b0, "R2 status ready before abort", {30'd0, sdo_oe, sdo}, 32'h2);
    repeat (DI / 2) @(negedge clk);
    cs_n = 1'b1;
    seen = 0;
    repeat (DI + 10) begin
      @(negedge clk);
      if (sck || conv_start) seen = 1;
    end
    chk(!seen, "R4 no sck or start after abort", 32'(seen), 0);
    chk(!sdo_oe, "R1 R4 high impedance after abort", 32'(sdo_oe), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(!sdo_oe && !sck && !conv_start && !cfg_valid, "R1 reset state",
        {28'd0, sdo_oe, sck, conv_start, cfg_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sdo_oe, "R1 idle after reset", 32'(sdo_oe), 0);
    do_read(1'b0, '0, 24'hC3A50F, 1'b0, 1);
    repeat (BUSY + 50) @(negedge clk);
    do_read(1'b0, res_of(0), 24'h5A0FF1, 1'b1, 1);
    // R8: next frame opened while the conversion is still running
    do_read(1'b1, res_of(1), 24'h800001, 1'b0, 0);
    repeat (BUSY + 50) @(negedge clk);
    do_abort();
    // R4: the result survives the abort
    do_read(1'b0, res_of(2), 24'h7E1234, 1'b0, 1);
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end
endmodule